// File: doc/BRIEF.md
# Quasi-Bidirectional I/O Port with Alternate Functions

This block is one parallel port of a microcontroller-style peripheral set. Each pin owns a storage bit (the output latch) that software writes as a whole byte or one bit at a time. The latch decides what the pin does. A latch holding 0 pulls the pin low. A latch holding 1 releases the pin so that it can act as an input. By default the released pin sits at a weak high level that any external device can override. In the floating variant the released pin is not driven at all.

Each pin can also be handed to an alternate function, such as a serial line or an interrupt request. The alternate-function output only reaches the pin while the latch of that pin holds 1. A separate mode input switches the whole port to carrying an external-memory address/data bus. In that mode the pins follow the bus value with strong drive in both directions. Latch writes are ignored in this mode, so the latch keeps its contents for when the port returns to ordinary I/O.

Pin levels pass through a two-stage synchronizer before they reach the read-pin data and the alternate-function inputs. The read-latch data returns the stored latch value, which read-modify-write bit operations rely on. Drive levels are abstracted into three enables per pin: strong low, strong high and weak pull-up.

Top module: `qbd_port`

## Requirements
- R1: While `rst_n` is low and after its release, every latch bit is 1 (`rd_latch` all ones) and every synchronizer stage holds 1 (`rd_pin` all ones) until a new pin level has been sampled.
- R2: With `addr_mode` low, `wr_byte_en` high at a rising clock edge loads `wr_byte_data` into all latch bits, visible on `rd_latch` after that edge.
- R3: With `addr_mode` low, `wr_bit_en` high at a rising edge loads `wr_bit_val` into latch bit `wr_bit_sel` only. When both write enables are high at the same edge, the byte is loaded first and the single-bit write then overrides its selected bit.
- R4: In I/O mode (`addr_mode` low), a pin whose latch holds 0 has `drv_lo` = 1, `drv_hi` = 0 and `pu_en` = 0, whatever its alternate-function inputs are.
- R5: With `TRUE_BIDIR` = 0, in I/O mode a pin whose latch holds 1 and whose alternate function is off has `drv_lo` = 0, `drv_hi` = 0 and `pu_en` = 1. An external device pulling that pin low makes it read 0.
- R6: With `TRUE_BIDIR` = 1, in I/O mode a pin whose effective output value is 1 has all three enables at 0 (floating), and `pu_en` is never 1.
- R7: With `alt_en[i]` = 1 in I/O mode, the effective output value of pin i is `latch[i] AND alt_out[i]`. A value of 0 gives strong low. A value of 1 gives the released state of R5 or R6.
- R8: With `addr_mode` = 1, every pin has `drv_hi` = `bus_out[i]`, `drv_lo` = NOT `bus_out[i]` and `pu_en` = 0, independent of latch and alternate-function settings. No pin ever has `drv_lo` together with `drv_hi` or `pu_en`.
- R9: Byte and bit writes at edges where `addr_mode` = 1 are ignored and `rd_latch` holds steady. On return to I/O mode the pins are driven from the preserved latch value.
- R10: `rd_pin` and `alt_in` both equal the `pin_in` value sampled two rising edges earlier.
- R11: `rd_latch` always shows the current latch contents, independent of pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_byte_en | input | 1 | Whole-latch write strobe |
| wr_byte_data | input | WIDTH | Data for a whole-latch write |
| wr_bit_en | input | 1 | Single-bit write strobe |
| wr_bit_sel | input | $clog2(WIDTH) | Index of the bit to write |
| wr_bit_val | input | 1 | Value for a single-bit write |
| addr_mode | input | 1 | 1 = port carries the external address/data bus |
| bus_out | input | WIDTH | Address/data value driven in bus mode |
| alt_en | input | WIDTH | Per-pin alternate-function select |
| alt_out | input | WIDTH | Per-pin alternate-function output value |
| pin_in | input | WIDTH | Sensed pin levels |
| drv_lo | output | WIDTH | Strong pull-down enable per pin |
| drv_hi | output | WIDTH | Strong pull-up enable per pin |
| pu_en | output | WIDTH | Weak pull-up enable per pin |
| rd_pin | output | WIDTH | Synchronized pin levels |
| rd_latch | output | WIDTH | Latch contents |
| alt_in | output | WIDTH | Synchronized pin levels for alternate-function inputs |

## Verification
The bench builds two instances with `WIDTH` = 8. One uses `TRUE_BIDIR` = 0 and the other `TRUE_BIDIR` = 1, so the weak-pull-up release and the floating release are both observed under identical stimulus. A bench-side pin model combines the drive enables with an external pull-low mask and a floating level. Through the two-stage synchronizer, this shows that an external low wins over the weak pull-up and that an undriven pin reads whatever the environment leaves on it. With a 3-bit select, single-bit writes reach both the lowest and highest pins, as well as the same-edge byte-plus-bit ordering.

// File: rtl/qbd_port_pkg.sv
package qbd_port_pkg;

    // Drive state requested for one pin
    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_LOW  = 2'd1,
        DRV_HIGH = 2'd2,
        DRV_WEAK = 2'd3
    } pin_drv_e;

    // Physical enables derived from a drive state
    typedef struct packed {
        logic lo;
        logic hi;
        logic pu;
    } pin_ctl_t;

    function automatic pin_ctl_t drv_to_ctl(input pin_drv_e drv);
        pin_ctl_t c;
        c = '0;
        case (drv)
            DRV_LOW:  c.lo = 1'b1;
            DRV_HIGH: c.hi = 1'b1;
            DRV_WEAK: c.pu = 1'b1;
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/qbd_latch_bank.sv
module qbd_latch_bank #(
    parameter int WIDTH = 8,
    parameter int SEL_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             byte_en,
    input  logic [WIDTH-1:0] byte_data,
    input  logic             bit_en,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic             bit_val,
    output logic [WIDTH-1:0] latch_q
);

    typedef struct packed {
        logic [WIDTH-1:0] latch;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!hold) begin
            if (byte_en) begin
                st_d.latch = byte_data;
            end
            // single-bit write lands after the byte so it wins on its bit
            if (bit_en && (int'(bit_sel) < WIDTH)) begin
                st_d.latch[bit_sel] = bit_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_q = st_q.latch;

endmodule

// File: rtl/qbd_sync.sv
module qbd_sync #(
    parameter int   WIDTH    = 8,
    parameter int   STAGES   = 2,
    parameter logic RST_ONES = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            st_d.stage[k] = st_q.stage[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ONES ? '1 : '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.stage[STAGES-1];

endmodule

// File: rtl/qbd_pin_cell.sv
module qbd_pin_cell
    import qbd_port_pkg::*;
#(
    parameter bit TRUE_BIDIR = 1'b0
) (
    input  logic bus_mode,
    input  logic bus_bit,
    input  logic latch_bit,
    input  logic alt_sel,
    input  logic alt_bit,
    output logic drv_lo,
    output logic drv_hi,
    output logic pu_en
);

    pin_drv_e drv;
    pin_ctl_t ctl;
    logic     out_val;

    always_comb begin
        // the alternate output can only pull low; a 0 latch always wins
        out_val = latch_bit & (~alt_sel | alt_bit);
        if (bus_mode) begin
            drv = bus_bit ? DRV_HIGH : DRV_LOW;
        end else if (!out_val) begin
            drv = DRV_LOW;
        end else if (TRUE_BIDIR) begin
            drv = DRV_NONE;
        end else begin
            drv = DRV_WEAK;
        end
        ctl = drv_to_ctl(drv);
    end

    assign drv_lo = ctl.lo;
    assign drv_hi = ctl.hi;
    assign pu_en  = ctl.pu;

endmodule

// File: rtl/qbd_port.sv
module qbd_port #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit TRUE_BIDIR  = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_byte_en,
    input  logic [WIDTH-1:0]         wr_byte_data,
    input  logic                     wr_bit_en,
    input  logic [$clog2(WIDTH)-1:0] wr_bit_sel,
    input  logic                     wr_bit_val,
    input  logic                     addr_mode,
    input  logic [WIDTH-1:0]         bus_out,
    input  logic [WIDTH-1:0]         alt_en,
    input  logic [WIDTH-1:0]         alt_out,
    input  logic [WIDTH-1:0]         pin_in,
    output logic [WIDTH-1:0]         drv_lo,
    output logic [WIDTH-1:0]         drv_hi,
    output logic [WIDTH-1:0]         pu_en,
    output logic [WIDTH-1:0]         rd_pin,
    output logic [WIDTH-1:0]         rd_latch,
    output logic [WIDTH-1:0]         alt_in
);

    localparam int SEL_W = $clog2(WIDTH);

    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] pin_sync;

    qbd_latch_bank #(
        .WIDTH (WIDTH),
        .SEL_W (SEL_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (addr_mode),
        .byte_en   (wr_byte_en),
        .byte_data (wr_byte_data),
        .bit_en    (wr_bit_en),
        .bit_sel   (wr_bit_sel),
        .bit_val   (wr_bit_val),
        .latch_q   (latch_q)
    );

    qbd_sync #(
        .WIDTH    (WIDTH),
        .STAGES   (SYNC_STAGES),
        .RST_ONES (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_sync)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        qbd_pin_cell #(
            .TRUE_BIDIR (TRUE_BIDIR)
        ) u_cell (
            .bus_mode  (addr_mode),
            .bus_bit   (bus_out[i]),
            .latch_bit (latch_q[i]),
            .alt_sel   (alt_en[i]),
            .alt_bit   (alt_out[i]),
            .drv_lo    (drv_lo[i]),
            .drv_hi    (drv_hi[i]),
            .pu_en     (pu_en[i])
        );
    end

    assign rd_latch = latch_q;
    assign rd_pin   = pin_sync;
    assign alt_in   = pin_sync;

endmodule

// File: rtl/qbd_port_chk.sv
module qbd_port_chk #(
    parameter int WIDTH      = 8,
    parameter bit TRUE_BIDIR = 1'b0
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_byte_en,
    input logic                     wr_bit_en,
    input logic [$clog2(WIDTH)-1:0] wr_bit_sel,
    input logic                     addr_mode,
    input logic [WIDTH-1:0]         bus_out,
    input logic [WIDTH-1:0]         drv_lo,
    input logic [WIDTH-1:0]         drv_hi,
    input logic [WIDTH-1:0]         pu_en,
    input logic [WIDTH-1:0]         rd_latch
);

    AST_BUS_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        addr_mode |=> $stable(rd_latch)); // R9

    AST_ZERO_LATCH_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_mode |-> ((~rd_latch & ~drv_lo) == '0)); // R4

    AST_NO_HIGH_WITHOUT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_mode |-> (((drv_hi | pu_en) & ~rd_latch) == '0)); // R7

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_lo & (drv_hi | pu_en)) == '0)); // R8

    AST_BUS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        addr_mode |-> (drv_hi == bus_out && drv_lo == ~bus_out && pu_en == '0)); // R8

    AST_BIT_WRITE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bit_en && !wr_byte_en && !addr_mode)
            |=> ($countones(rd_latch ^ $past(rd_latch)) <= 1)); // R3

    if (TRUE_BIDIR) begin : g_float
        AST_FLOAT_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
            (pu_en == '0)); // R6
    end

    logic unused_sel;
    assign unused_sel = ^wr_bit_sel;

endmodule

bind qbd_port qbd_port_chk #(
    .WIDTH      (WIDTH),
    .TRUE_BIDIR (TRUE_BIDIR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_byte_en (wr_byte_en),
    .wr_bit_en  (wr_bit_en),
    .wr_bit_sel (wr_bit_sel),
    .addr_mode  (addr_mode),
    .bus_out    (bus_out),
    .drv_lo     (drv_lo),
    .drv_hi     (drv_hi),
    .pu_en      (pu_en),
    .rd_latch   (rd_latch)
);

// File: tb/qbd_port_bench.sv
`timescale 1ns/1ps
module qbd_port_bench;

    localparam int W  = 8;
    localparam int SW = $clog2(W);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_byte_en, wr_bit_en, wr_bit_val, addr_mode;
    logic [W-1:0]  wr_byte_data, bus_out, alt_en, alt_out, ext_lo, float_lvl;
    logic [SW-1:0] wr_bit_sel;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // next latch value from the requirements (R2, R3, R9)
    function automatic logic [W-1:0] next_latch(input logic [W-1:0] cur);
        logic [W-1:0] r;
        r = cur;
        if (!addr_mode) begin
            if (wr_byte_en) r = wr_byte_data;
            if (wr_bit_en)  r[wr_bit_sel] = wr_bit_val;
        end
        return r;
    endfunction

    // expected {lo, hi, pu} from the requirements (R4..R8)
    function automatic logic [3*W-1:0] exp_drv(input int flt, input logic [W-1:0] lat);
        logic [W-1:0] lo, hi, pu, v;
        if (addr_mode) begin
            hi = bus_out; lo = ~bus_out; pu = '0;
        end else begin
            v  = lat & (~alt_en | alt_out);
            lo = ~v; hi = '0;
            pu = (flt != 0) ? '0 : v;
        end
        return {lo, hi, pu};
    endfunction

    for (genvar v = 0; v < 2; v++) begin : g_v
        logic [W-1:0]   lo, hi, pu, rp, rl, ai, pins;
        logic [W-1:0]   m_latch, m_s1, m_s2;
        logic [3*W-1:0] e;

        qbd_port #(.WIDTH(W), .SYNC_STAGES(2), .TRUE_BIDIR(v)) u_qbd_port (
            .clk(clk), .rst_n(rst_n),
            .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
            .wr_bit_en(wr_bit_en), .wr_bit_sel(wr_bit_sel), .wr_bit_val(wr_bit_val),
            .addr_mode(addr_mode), .bus_out(bus_out),
            .alt_en(alt_en), .alt_out(alt_out), .pin_in(pins),
            .drv_lo(lo), .drv_hi(hi), .pu_en(pu),
            .rd_pin(rp), .rd_latch(rl), .alt_in(ai)
        );

        // board model: strong drive, then external pull-low, then weak pull-up, else float level
        always_comb begin
            for (int i = 0; i < W; i++) begin
                if (lo[i])          pins[i] = 1'b0;
                else if (hi[i])     pins[i] = 1'b1;
                else if (ext_lo[i]) pins[i] = 1'b0;
                else if (pu[i])     pins[i] = 1'b1;
                else                pins[i] = float_lvl[i];
            end
        end

        always @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m_latch <= '1; m_s1 <= '1; m_s2 <= '1;
            end else begin
                m_latch <= next_latch(m_latch);
                m_s1    <= pins;
                m_s2    <= m_s1;
            end
        end

        always @(negedge clk) begin
            if (rst_n && !done) begin
                e = exp_drv(v, m_latch);
                check(addr_mode ? "R8" : "R4 R5 R6 R7", "drv_lo", lo, e[3*W-1:2*W]);
                check(addr_mode ? "R8" : "R4 R5 R6 R7", "drv_hi", hi, e[2*W-1:W]);
                check(addr_mode ? "R8" : "R5 R6",       "pu_en",  pu, e[W-1:0]);
                check("R2 R11", "rd_latch", rl, m_latch);
                check("R10",    "rd_pin",   rp, m_s2);
                check("R10",    "alt_in",   ai, m_s2);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        wr_byte_en = 0; wr_bit_en = 0; wr_bit_val = 0; addr_mode = 0;
        wr_byte_data = '0; wr_bit_sel = '0; bus_out = '0;
        alt_en = '0; alt_out = '0; ext_lo = '0; float_lvl = '0;
        repeat (3) step();
        // R1: values under reset
        check("R1", "rd_latch reset v0", g_v[0].rl, 8'hFF);
        check("R1", "rd_latch reset v1", g_v[1].rl, 8'hFF);
        check("R1", "rd_pin reset v0",   g_v[0].rp, 8'hFF);
        rst_n = 1'b1;
        step();
        check("R1", "rd_latch after release", g_v[0].rl, 8'hFF);
        check("R5", "pu_en released", g_v[0].pu, 8'hFF);

        // R2 byte write
        wr_byte_en = 1; wr_byte_data = 8'h5A;
        step();
        wr_byte_en = 0;
        check("R2", "rd_latch byte", g_v[0].rl, 8'h5A);
        check("R4", "drv_lo zeros",  g_v[0].lo, 8'hA5);

        // R3 bit write at bit 0
        wr_bit_en = 1; wr_bit_sel = 3'd0; wr_bit_val = 1;
        step();
        wr_bit_en = 0;
        check("R3", "rd_latch bit0", g_v[0].rl, 8'h5B);

        // R3 byte and bit at the same edge, top bit
        wr_byte_en = 1; wr_byte_data = 8'h00;
        wr_bit_en = 1; wr_bit_sel = 3'd7; wr_bit_val = 1;
        step();
        wr_byte_en = 0; wr_bit_en = 0;
        check("R3", "rd_latch byte+bit", g_v[1].rl, 8'h80);

        // R5 / R6 external pull-low through the synchronizer
        wr_byte_en = 1; wr_byte_data = 8'hFF;
        step();
        wr_byte_en = 0;
        ext_lo = 8'h0F;
        repeat (3) step();
        check("R5",  "rd_pin ext low v0",  g_v[0].rp, 8'hF0);
        check("R10", "alt_in ext low v0",  g_v[0].ai, 8'hF0);
        check("R5",  "drv_lo released v0", g_v[0].lo, 8'h00);
        check("R6",  "pu_en float v1",     g_v[1].pu, 8'h00);
        check("R6",  "drv_hi float v1",    g_v[1].hi, 8'h00);
        check("R6",  "rd_pin float low v1", g_v[1].rp, 8'h00);
        float_lvl = 8'hFF;
        repeat (3) step();
        check("R6",  "rd_pin float high v1", g_v[1].rp, 8'hF0);
        ext_lo = '0;

        // R7 alternate function gated by the latch
        alt_en = 8'h03; alt_out = 8'h01;
        step();
        check("R7", "drv_lo alt v0", g_v[0].lo, 8'h02);
        check("R7", "pu_en alt v0",  g_v[0].pu, 8'hFD);
        wr_bit_en = 1; wr_bit_sel = 3'd0; wr_bit_val = 0;
        step();
        wr_bit_en = 0;
        check("R7", "drv_lo latch0 over alt", g_v[0].lo, 8'h03);
        alt_en = '0;

        // R8 / R9 bus mode preserves the latch
        wr_byte_en = 1; wr_byte_data = 8'h3C;
        step();
        addr_mode = 1; bus_out = 8'hA5;
        wr_byte_data = 8'h00; wr_bit_en = 1; wr_bit_sel = 3'd2; wr_bit_val = 0;
        step();
        wr_byte_en = 0; wr_bit_en = 0;
        check("R8", "drv_hi bus", g_v[0].hi, 8'hA5);
        check("R8", "drv_lo bus", g_v[1].lo, 8'h5A);
        check("R8", "pu_en bus",  g_v[0].pu, 8'h00);
        check("R9", "rd_latch held", g_v[0].rl, 8'h3C);
        step();
        addr_mode = 0;
        step();
        check("R9", "drv_lo after bus", g_v[0].lo, 8'hC3);
        check("R9", "rd_latch after bus", g_v[0].rl, 8'h3C);

        // mixed traffic checked every clock against the model
        for (int n = 0; n < 400; n++) begin
            wr_byte_en   = ($urandom_range(3) == 0);
            wr_byte_data = W'($urandom);
            wr_bit_en    = ($urandom_range(2) == 0);
            wr_bit_sel   = SW'($urandom);
            wr_bit_val   = ($urandom_range(1) == 1);
            addr_mode    = ($urandom_range(5) == 0);
            bus_out      = W'($urandom);
            alt_en       = W'($urandom);
            alt_out      = W'($urandom);
            ext_lo       = W'($urandom) & W'($urandom);
            float_lvl    = W'($urandom);
            step();
        end
        finish_run();
    end

endmodule